// File: doc/BRIEF.md
# Programmable SPI serial clock generator

This block derives the serial clock of an SPI master from its faster parent clock. A single 32-bit configuration word sets the length of the serial clock period and the two points within that period where the clock rises and falls. A free-running phase counter steps from 0 up to the divider value and wraps. The clock output goes high on the count that matches the high position and low on the count that matches the low position. Alongside the clock level, the block gives one-cycle pulses on each rising and falling edge, which a shift engine can use to launch and capture data.

The generator runs only while the transfer enable input is high. When enable is low, the counter is held at zero and the clock is parked low. Software normally sets the divider n to parent_rate/speed - 1 with a floor of 1. It sets the low position to n and the high position to (n+1)/2 - 1, which gives close to a 50 % duty cycle. With those settings the serial clock spans parent/64 to parent/2. The source select bit is kept in the word and shown on an output, but the block does not act on it.

Edge control is a three-state machine. PARK is the state while disabled. RUN_LO is running with the clock low, and RUN_HI is running with the clock high. The transitions are:

- START: PARK to RUN_LO, taken when enable rises and the high position is not yet reached.
- RISE: PARK or RUN_LO to RUN_HI, taken when the count equals the high position and does not equal the low position.
- FALL: RUN_HI to RUN_LO, taken when the count equals the low position.
- STOP: any state to PARK, taken when enable is low.

Top module: `spi_sclk_gen`

## Requirements
- R1: After reset, the clock output, both edge pulses and the source select output are 0, and the stored word is all zeros.
- R2: Configuration word layout is fixed: bit 31 is the source select, bits 17:12 the divider n, bits 11:6 the high position, bits 5:0 the low position. A write sets the source select output from the edge that takes the write.
- R3: While enabled, the phase counter runs 0..n and wraps, so one serial clock period is n+1 parent cycles and the counter never exceeds n.
- R4: At a clock edge where the generator is enabled, the serial clock is low and the count equals the high position (and not the low position), the clock goes high and the rise pulse is 1 for exactly that first high cycle.
- R5: At a clock edge where the generator is enabled, the serial clock is high and the count equals the low position, the clock goes low and the fall pulse is 1 for exactly that first low cycle.
- R6: After enable is first sampled high, the first edge is a rise, taken at the (high position + 1)-th sampling clock edge.
- R7: A divider value of 0 behaves as 1, so the shortest period is 2 parent cycles.
- R8: Enable low returns the counter to 0 and the clock low at the next edge, with no fall pulse. No pulse appears while enable is low.
- R9: A word written while running takes effect at the next wrap edge, including a wrap on the same edge as the write. When idle, it takes effect at once.
- R10: If the count equals both positions, the clock stays low. If the high position is above n, the clock never rises.
- R11: The rise and fall pulses are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word (layout per R2) |
| xfer_en | input | 1 | Transfer enable; the generator runs while high |
| sclk | output | 1 | Serial clock level |
| sclk_rise | output | 1 | One-cycle pulse in the first high cycle |
| sclk_fall | output | 1 | One-cycle pulse in the first low cycle after a high phase |
| src_sel | output | 1 | Stored source select bit |

## Verification
The hardest case to reach is a configuration write that arrives while the clock is running. The old word must keep shaping the current period until the wrap, and the new one must take over exactly there. A write that lands on the wrap edge itself is the sharpest form of this case.

A directed case covers a write in the middle of a period. It measures the uneven rise-to-rise interval that straddles the swap, then the new period. A long random run then drives writes at random cycles while enable toggles rarely. Random dividers and positions make writes on wrap edges, equal positions and positions beyond the divider all occur. Every cycle is compared with a bench model of the requirements.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;

    parameter int CFG_W   = 32;
    parameter int CNT_W   = 6;

    // Field positions inside the configuration word
    localparam int LO_LSB  = 0;
    localparam int HI_LSB  = LO_LSB + CNT_W;
    localparam int DIV_LSB = HI_LSB + CNT_W;
    localparam int SRC_BIT = CFG_W - 1;
    localparam int USED_W  = DIV_LSB + CNT_W;

    typedef enum logic [1:0] {
        ST_PARK   = 2'd0,
        ST_RUN_LO = 2'd1,
        ST_RUN_HI = 2'd2
    } sclk_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] div;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
    } phase_cfg_t;

    function automatic phase_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        phase_cfg_t c;
        c.div = w[DIV_LSB +: CNT_W];
        c.hi  = w[HI_LSB  +: CNT_W];
        c.lo  = w[LO_LSB  +: CNT_W];
        return c;
    endfunction

endpackage

// File: rtl/sclk_cfg_store.sv
module sclk_cfg_store
    import sclk_gen_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 load_now,
    output phase_cfg_t           act_cfg,
    output logic [CNT_W-1:0]     div_eff,
    output logic                 src_sel
);

    phase_cfg_t pend_q;
    phase_cfg_t act_q;
    phase_cfg_t wr_cfg;
    phase_cfg_t nxt_pend;
    logic       src_q;
    logic       unused_bits;

    assign wr_cfg      = unpack_cfg(cfg_wdata);
    assign nxt_pend    = cfg_we ? wr_cfg : pend_q;
    assign unused_bits = ^cfg_wdata[SRC_BIT-1:USED_W];

    // Pending copy: what software last wrote
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            src_q  <= 1'b0;
        end else if (cfg_we) begin
            pend_q <= wr_cfg;
            src_q  <= cfg_wdata[SRC_BIT];
        end
    end

    // Active copy: swapped only when idle or on a wrap edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (load_now) begin
            act_q <= nxt_pend;
        end
    end

    assign act_cfg = act_q;
    assign div_eff = (act_q.div == '0) ? CNT_W'(1) : act_q.div;
    assign src_sel = src_q;

endmodule

// File: rtl/sclk_phase_cnt.sv
module sclk_phase_cnt
    import sclk_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] div_eff,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    logic [CNT_W-1:0] cnt_q;

    assign wrap = run && (cnt_q == div_eff);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/sclk_edge_fsm.sv
module sclk_edge_fsm
    import sclk_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] hi_pos,
    input  logic [CNT_W-1:0] lo_pos,
    output logic             sclk,
    output logic             rise,
    output logic             fall
);

    sclk_state_e state_q;
    sclk_state_e state_d;
    logic        at_hi;
    logic        at_lo;
    logic        rise_q;
    logic        fall_q;

    assign at_hi = (cnt == hi_pos);
    assign at_lo = (cnt == lo_pos);

    // Next-state selection: START, RISE, FALL, STOP
    always_comb begin
        state_d = state_q;
        if (!run) begin
            state_d = ST_PARK;
        end else begin
            unique case (state_q)
                ST_PARK, ST_RUN_LO: begin
                    if (!at_lo && at_hi) state_d = ST_RUN_HI;
                    else                 state_d = ST_RUN_LO;
                end
                ST_RUN_HI: begin
                    if (at_lo) state_d = ST_RUN_LO;
                end
                default: state_d = ST_PARK;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PARK;
        else        state_q <= state_d;
    end

    // Edge pulses, registered alongside the state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            rise_q <= run && (state_q != ST_RUN_HI) && (state_d == ST_RUN_HI);
            fall_q <= run && (state_q == ST_RUN_HI) && (state_d == ST_RUN_LO);
        end
    end

    assign sclk = (state_q == ST_RUN_HI);
    assign rise = rise_q;
    assign fall = fall_q;

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
    import sclk_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             xfer_en,
    output logic             sclk,
    output logic             sclk_rise,
    output logic             sclk_fall,
    output logic             src_sel
);

    phase_cfg_t       act_cfg;
    logic [CNT_W-1:0] div_eff;
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;
    logic             load_now;

    assign load_now = !xfer_en || wrap;

    sclk_cfg_store u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .load_now  (load_now),
        .act_cfg   (act_cfg),
        .div_eff   (div_eff),
        .src_sel   (src_sel)
    );

    sclk_phase_cnt u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (xfer_en),
        .div_eff (div_eff),
        .cnt     (cnt_q),
        .wrap    (wrap)
    );

    sclk_edge_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (xfer_en),
        .cnt    (cnt_q),
        .hi_pos (act_cfg.hi),
        .lo_pos (act_cfg.lo),
        .sclk   (sclk),
        .rise   (sclk_rise),
        .fall   (sclk_fall)
    );

endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk
    import sclk_gen_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               xfer_en,
    input logic               sclk,
    input logic               sclk_rise,
    input logic               sclk_fall,
    input logic [CNT_W-1:0]   cnt,
    input logic [CNT_W-1:0]   div_eff,
    input logic [3*CNT_W-1:0] act_bits
);

    p_pulse_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_rise && sclk_fall));

    p_rise_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |-> (sclk && !$past(sclk)));

    p_fall_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_fall |-> (!sclk && $past(sclk)));

    p_run_fall_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sclk) && $past(xfer_en)) |-> sclk_fall);

    p_park_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(xfer_en) |-> (!sclk && !sclk_rise && !sclk_fall && cnt == '0));

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= div_eff);

    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_en && cnt != div_eff) |=> $stable(act_bits));

endmodule

bind spi_sclk_gen spi_sclk_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_en   (xfer_en),
    .sclk      (sclk),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cnt       (cnt_q),
    .div_eff   (div_eff),
    .act_bits  (act_cfg)
);

// File: tb/spi_sclk_gen_tb_top.sv
`timescale 1ns/1ps
module spi_sclk_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        xfer_en = 1'b0;
    logic        sclk, sclk_rise, sclk_fall, src_sel;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;
    string cur_tag = "R1";

    // Bench model state
    logic [5:0] m_pdiv, m_phi, m_plo;
    logic       m_psrc;
    logic [5:0] m_div, m_hi, m_lo, m_cnt;
    logic       m_hs, m_rise, m_fall;

    always #2.5 clk = ~clk;

    spi_sclk_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .xfer_en   (xfer_en),
        .sclk      (sclk),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .src_sel   (src_sel)
    );

    function automatic logic [31:0] mk(input logic s, input int n, input int h, input int l);
        logic [31:0] w = '0;
        w[31]    = s;
        w[17:12] = n[5:0];
        w[11:6]  = h[5:0];
        w[5:0]   = l[5:0];
        return w;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(input logic en, input logic we, input logic [31:0] d);
        logic [5:0] nd;
        logic       wrap, load;
        logic [5:0] wd, wh, wl;
        nd = (m_div == 6'd0) ? 6'd1 : m_div;
        wd = we ? d[17:12] : m_pdiv;
        wh = we ? d[11:6]  : m_phi;
        wl = we ? d[5:0]   : m_plo;
        m_rise = 1'b0;
        m_fall = 1'b0;
        if (!en) begin
            m_cnt = '0;
            m_hs  = 1'b0;
            load  = 1'b1;
        end else begin
            wrap = (m_cnt == nd);
            if (m_hs) begin
                if (m_cnt == m_lo) begin m_hs = 1'b0; m_fall = 1'b1; end
            end else if (m_cnt != m_lo && m_cnt == m_hi) begin
                m_hs = 1'b1; m_rise = 1'b1;
            end
            m_cnt = wrap ? 6'd0 : m_cnt + 6'd1;
            load  = wrap;
        end
        if (load) begin m_div = wd; m_hi = wh; m_lo = wl; end
        m_pdiv = wd; m_phi = wh; m_plo = wl;
        if (we) m_psrc = d[31];
    endtask

    // One parent cycle: drive at negedge, compare after posedge
    task automatic cyc(input logic en, input logic we, input logic [31:0] d);
        @(negedge clk);
        xfer_en   = en;
        cfg_we    = we;
        cfg_wdata = d;
        model_step(en, we, d);
        @(posedge clk);
        #1;
        chk({cur_tag, " sclk"}, int'(sclk), int'(m_hs));
        chk({cur_tag, " rise"}, int'(sclk_rise), int'(m_rise));
        chk({cur_tag, " fall"}, int'(sclk_fall), int'(m_fall));
        chk({cur_tag, " src"},  int'(src_sel), int'(m_psrc));
    endtask

    task automatic cycles_to_rise(output int k);
        k = 0;
        do begin cyc(1'b1, 1'b0, '0); k++; end while (!sclk_rise && k < 200);
    endtask

    task automatic cycles_to_fall(output int k);
        k = 0;
        do begin cyc(1'b1, 1'b0, '0); k++; end while (!sclk_fall && k < 200);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int k;
        int rises;
        logic [31:0] w;
        void'($urandom(32'd20240611));
        m_pdiv = '0; m_phi = '0; m_plo = '0; m_psrc = 1'b0;
        m_div = '0; m_hi = '0; m_lo = '0; m_cnt = '0;
        m_hs = 1'b0; m_rise = 1'b0; m_fall = 1'b0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 sclk", int'(sclk), 0);
        chk("R1 rise", int'(sclk_rise), 0);
        chk("R1 fall", int'(sclk_fall), 0);
        chk("R1 src", int'(src_sel), 0);
        cur_tag = "R1";
        repeat (10) cyc(1'b1, 1'b0, '0);   // all-zero word: never rises (R10 too)

        // R2 layout, R6 first-rise latency, R4/R5/R3 phase points
        cur_tag = "R2";
        cyc(1'b0, 1'b1, mk(1'b1, 5, 2, 5));
        chk("R2 src_sel after write", int'(src_sel), 1);
        cyc(1'b0, 1'b0, '0);
        cur_tag = "R6";
        cycles_to_rise(k);
        chk("R6 first rise latency", k, 3);
        chk("R4 sclk high with rise", int'(sclk), 1);
        cur_tag = "R5";
        cycles_to_fall(k);
        chk("R5 high phase length", k, 3);
        cur_tag = "R3";
        cycles_to_rise(k);
        chk("R3 low phase length", k, 3);
        cycles_to_rise(k);
        chk("R3 period n+1", k, 6);

        // R8 disable while high parks low without a fall pulse
        cur_tag = "R8";
        cyc(1'b1, 1'b0, '0);
        chk("R8 sclk high before stop", int'(sclk), 1);
        cyc(1'b0, 1'b0, '0);
        chk("R8 parked low", int'(sclk), 0);
        chk("R8 no fall pulse", int'(sclk_fall), 0);
        rises = 0;
        for (int i = 0; i < 20; i++) begin
            cyc(1'b0, 1'b0, '0);
            rises += int'(sclk_rise) + int'(sclk_fall) + int'(sclk);
        end
        chk("R8 quiet while disabled", rises, 0);
        cycles_to_rise(k);
        chk("R8 restart from zero", k, 3);

        // R7 divider zero behaves as one
        cur_tag = "R7";
        cyc(1'b0, 1'b1, mk(1'b0, 0, 0, 1));
        cycles_to_rise(k);
        chk("R7 first rise", k, 1);
        cycles_to_rise(k);
        chk("R7 period of 2", k, 2);

        // R10 equal positions and high position beyond n
        cur_tag = "R10";
        cyc(1'b0, 1'b1, mk(1'b0, 9, 4, 4));
        rises = 0;
        for (int i = 0; i < 60; i++) begin cyc(1'b1, 1'b0, '0); rises += int'(sclk_rise); end
        chk("R10 equal positions no rise", rises, 0);
        cyc(1'b0, 1'b1, mk(1'b0, 3, 10, 3));
        rises = 0;
        for (int i = 0; i < 60; i++) begin cyc(1'b1, 1'b0, '0); rises += int'(sclk_rise); end
        chk("R10 high beyond n no rise", rises, 0);

        // R9 write mid-period waits for the wrap
        cur_tag = "R9";
        cyc(1'b0, 1'b1, mk(1'b0, 7, 3, 7));
        cycles_to_rise(k);
        chk("R9 old config first rise", k, 4);
        cyc(1'b1, 1'b1, mk(1'b0, 3, 1, 3));
        cycles_to_rise(k);
        chk("R9 straddling interval", k + 1, 6);
        cycles_to_rise(k);
        chk("R9 new period", k, 4);

        // Random phase: writes at any cycle, rare enable toggles
        cur_tag = "R9 random";
        for (int i = 0; i < 6000; i++) begin
            logic en_r, we_r;
            int n, h, l;
            en_r = xfer_en;
            if ($urandom % 50 == 0) en_r = ~en_r;
            we_r = ($urandom % 40 == 0);
            n = $urandom % 64;
            if ($urandom % 4 != 0) begin
                if (n == 0) n = 1;
                h = (n + 1) / 2 - 1;
                l = n;
            end else begin
                h = $urandom % 64;
                l = $urandom % 64;
            end
            w = mk(1'($urandom % 2), n, h, l);
            cyc(en_r, we_r, we_r ? w : 32'd0);
        end
        cyc(1'b0, 1'b0, '0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule